// File: doc/BRIEF.md
# Commit-Stage Squash Controller

This block decides, for each hardware thread of an out-of-order core, when the commit stage must throw away in-flight instructions, and it works out the sequence-number boundary for that flush. It has three sources of flush requests. The first is a trap, which is armed by a trap request and fires only after a programmable number of cycles. The second is a thread-context request, which flushes the whole thread at once. The third is a request from the execute stage, which carries a sequence number and flags that describe a branch outcome.

When the controller accepts a flush, it emits a one-cycle pulse carrying the boundary that the reorder buffer uses, the completed sequence number, a redirect PC and a flag that says whether the branch delay slot is discarded. The thread then stays in a flushing state until the reorder buffer reports that it has finished. Each thread keeps a record of its youngest live sequence number. The dispatch side updates that record, and the controller uses it to drop execute-stage requests that are stale.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset, every thread has `sq_vld`, `squashing`, `trap_pend` and `conflict` at 0, all data outputs at 0, and a youngest sequence number of 0.
- R2: A `trap_req` sampled at a clock edge raises `trap_pend` after that edge. With a latency of L, the thread-wide flush pulse `sq_vld` appears after the (L+1)-th following edge, and `trap_pend` falls at the same edge. A new `trap_req` while pending reloads the count.
- R3: When a trap fires in the same cycle that a context request is pending, the trap flush is taken and `conflict` pulses with it. The context request stays pending and is flushed at the next edge, with `conflict` low.
- R4: A trap or context flush discards the whole thread. `sq_bound` and `sq_done` both equal the head sequence number minus one, or 0 when `rob_empty` is set. `sq_slot_kill` is 0, `sq_pc` is `restart_pc`, and the youngest sequence number becomes 0.
- R5: An execute request is accepted only when the thread has no trap pending and `exe_seq` is less than or equal to the youngest sequence number, compared as unsigned values. A rejected request produces no pulse.
- R6: For an accepted execute request, the boundary is set as follows. A mispredicted, taken branch with a conditional delay slot gives a boundary of `exe_seq` and sets `sq_slot_kill` to 1. Any other mispredict gives a boundary of `exe_seq`+1 and sets `sq_slot_kill` to 0. A request without a mispredict gives a boundary of `exe_seq` and sets `sq_slot_kill` to 0. In all cases `sq_done` is `exe_seq` and `sq_pc` is `exe_pc`.
- R7: When `exe_incl_self` is set, both `sq_done` and `sq_bound` are one less than the values given in R6.
- R8: After an accepted execute flush, the youngest sequence number becomes `sq_done`, so a later request with a larger sequence number is rejected.
- R9: `squashing` is set at the edge that accepts a flush. It stays set on every edge after that while `rob_done` is low, and it clears at the first edge with `rob_done` high.
- R10: `sq_vld` lasts exactly one cycle per accepted flush. The data outputs hold their values until the next accepted flush.
- R11: `disp_vld` loads `disp_seq` as the youngest sequence number, unless a flush is accepted in the same cycle.
- R12: In a cycle with a trap or context flush, any execute request of that thread is ignored.
- R13: Threads are independent. A request on one thread never affects the outputs or the youngest record of another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_latency | input | LAT_W | Trap delay in cycles |
| trap_req | input | NUM_THR | Arm the trap timer, one bit per thread |
| ctx_req | input | NUM_THR | Whole-thread context flush request |
| exe_vld | input | NUM_THR | Execute-stage flush request |
| exe_seq | input | NUM_THR*SEQ_W | Sequence number of the flushing instruction |
| exe_mispredict | input | NUM_THR | Request comes from a mispredicted branch |
| exe_taken | input | NUM_THR | Branch was taken |
| exe_cond_slot | input | NUM_THR | Branch has a conditional delay slot |
| exe_incl_self | input | NUM_THR | Flush includes the flushing instruction itself |
| exe_pc | input | NUM_THR*PC_W | Redirect PC for execute flushes |
| disp_vld | input | NUM_THR | Dispatch update of the youngest sequence number |
| disp_seq | input | NUM_THR*SEQ_W | Newly dispatched youngest sequence number |
| rob_empty | input | NUM_THR | Reorder buffer of the thread is empty |
| rob_head_seq | input | NUM_THR*SEQ_W | Sequence number at the reorder buffer head |
| rob_done | input | NUM_THR | Reorder buffer has finished flushing |
| restart_pc | input | NUM_THR*PC_W | Redirect PC for trap and context flushes |
| sq_vld | output | NUM_THR | One-cycle flush pulse |
| sq_bound | output | NUM_THR*SEQ_W | Reorder buffer flush boundary |
| sq_done | output | NUM_THR*SEQ_W | Done sequence number |
| sq_slot_kill | output | NUM_THR | Delay slot is discarded |
| sq_pc | output | NUM_THR*PC_W | Redirect PC |
| squashing | output | NUM_THR | Flush in progress |
| trap_pend | output | NUM_THR | Trap timer armed |
| conflict | output | NUM_THR | Trap and context flush collided |

## Verification
The hardest case to reach is a trap that fires in the same cycle that a context flush is pending. To set it up, the bench programs a latency of zero, pulses `trap_req`, and drives `ctx_req` in exactly the cycle the timer expires. The scoreboard then expects two flushes on consecutive edges, the first one carrying `conflict`.

Execute requests made while a trap is pending use sequence numbers that the youngest-number filter would otherwise accept, so that a missing pulse can only come from the trap gate. The same approach applies to an execute request that arrives together with a context flush: its number would otherwise pass the filter, and the expected boundary differs from the one the execute request would produce.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic {
    THR_RUN    = 1'b0,
    THR_FLUSH  = 1'b1
  } thr_st_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_WHOLE,
    SRC_EXE
  } sq_src_e;
endpackage

// File: rtl/sq_trap_timer.sv
module sq_trap_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LAT_W-1:0] latency,
  output logic             pending,
  output logic             fire
);
  logic             armed_q, armed_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (req) begin
      armed_d = 1'b1;
      cnt_d   = latency;
      cnt_en  = 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        armed_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - LAT_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pending = armed_q;
  assign fire    = armed_q && (cnt_q == '0) && !req;

  AST_TIMER_FIRE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pending) else $error("timer stays armed after firing"); // R2
endmodule

// File: rtl/sq_boundary.sv
module sq_boundary #(
  parameter int SEQ_W = 32
) (
  input  logic [SEQ_W-1:0] seq,
  input  logic             mispredict,
  input  logic             taken,
  input  logic             cond_slot,
  input  logic             incl_self,
  output logic [SEQ_W-1:0] bound,
  output logic [SEQ_W-1:0] done,
  output logic             slot_kill
);
  logic [SEQ_W-1:0] bound_raw;

  always_comb begin
    slot_kill = 1'b0;
    bound_raw = seq;
    if (mispredict) begin
      if (taken && cond_slot) begin
        slot_kill = 1'b1;
      end else begin
        bound_raw = seq + SEQ_W'(1);
      end
    end
    if (incl_self) begin
      bound = bound_raw - SEQ_W'(1);
      done  = seq - SEQ_W'(1);
    end else begin
      bound = bound_raw;
      done  = seq;
    end
  end
endmodule

// File: rtl/sq_thread.sv
module sq_thread
  import sq_pkg::*;
#(
  parameter int SEQ_W = 32,
  parameter int PC_W  = 32,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] trap_latency,
  input  logic             trap_req,
  input  logic             ctx_req,
  input  logic             exe_vld,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_mispredict,
  input  logic             exe_taken,
  input  logic             exe_cond_slot,
  input  logic             exe_incl_self,
  input  logic [PC_W-1:0]  exe_pc,
  input  logic             disp_vld,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_done,
  input  logic [PC_W-1:0]  restart_pc,
  output logic             sq_vld,
  output logic [SEQ_W-1:0] sq_bound,
  output logic [SEQ_W-1:0] sq_done,
  output logic             sq_slot_kill,
  output logic [PC_W-1:0]  sq_pc,
  output logic             squashing,
  output logic             trap_pend,
  output logic             conflict
);
  logic             fire;
  logic             ctx_pend_q, ctx_pend_d, ctx_eff;
  thr_st_e          st_q, st_d;
  sq_src_e          src;
  logic [SEQ_W-1:0] young_q, young_d;
  logic             young_en;
  logic [SEQ_W-1:0] exe_bound, exe_done, whole_bound;
  logic             exe_kill;
  logic             accept;
  logic             vld_q, sqing_q, conf_q, kill_q;
  logic [SEQ_W-1:0] bound_q, done_q, bound_d, done_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             kill_d;

  sq_trap_timer #(.LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (trap_req),
    .latency (trap_latency),
    .pending (trap_pend),
    .fire    (fire)
  );

  sq_boundary #(.SEQ_W(SEQ_W)) u_bound (
    .seq        (exe_seq),
    .mispredict (exe_mispredict),
    .taken      (exe_taken),
    .cond_slot  (exe_cond_slot),
    .incl_self  (exe_incl_self),
    .bound      (exe_bound),
    .done       (exe_done),
    .slot_kill  (exe_kill)
  );

  assign ctx_eff     = ctx_pend_q | ctx_req;
  assign whole_bound = rob_empty ? '0 : (rob_head_seq - SEQ_W'(1));

  always_comb begin
    if (fire || ctx_eff)
      src = SRC_WHOLE;
    else if (exe_vld && !trap_pend && (exe_seq <= young_q))
      src = SRC_EXE;
    else
      src = SRC_NONE;
  end

  assign accept = (src != SRC_NONE);

  always_comb begin
    bound_d  = bound_q;
    done_d   = done_q;
    kill_d   = kill_q;
    pc_d     = pc_q;
    young_d  = young_q;
    young_en = 1'b0;
    case (src)
      SRC_WHOLE: begin
        bound_d  = whole_bound;
        done_d   = whole_bound;
        kill_d   = 1'b0;
        pc_d     = restart_pc;
        young_d  = '0;
        young_en = 1'b1;
      end
      SRC_EXE: begin
        bound_d  = exe_bound;
        done_d   = exe_done;
        kill_d   = exe_kill;
        pc_d     = exe_pc;
        young_d  = exe_done;
        young_en = 1'b1;
      end
      default: begin
        if (disp_vld) begin
          young_d  = disp_seq;
          young_en = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    ctx_pend_d = ctx_eff & fire;
    if (accept)
      st_d = THR_FLUSH;
    else if (st_q == THR_FLUSH && rob_done)
      st_d = THR_RUN;
    else
      st_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= THR_RUN;
      ctx_pend_q <= 1'b0;
      young_q    <= '0;
      vld_q      <= 1'b0;
      sqing_q    <= 1'b0;
      conf_q     <= 1'b0;
      kill_q     <= 1'b0;
      bound_q    <= '0;
      done_q     <= '0;
      pc_q       <= '0;
    end else begin
      st_q       <= st_d;
      ctx_pend_q <= ctx_pend_d;
      vld_q      <= accept;
      sqing_q    <= accept | ((st_q == THR_FLUSH) & ~rob_done);
      conf_q     <= fire & ctx_eff;
      if (young_en) young_q <= young_d;
      if (accept) begin
        kill_q  <= kill_d;
        bound_q <= bound_d;
        done_q  <= done_d;
        pc_q    <= pc_d;
      end
    end
  end

  assign sq_vld       = vld_q;
  assign sq_bound     = bound_q;
  assign sq_done      = done_q;
  assign sq_slot_kill = kill_q;
  assign sq_pc        = pc_q;
  assign squashing    = sqing_q;
  assign conflict     = conf_q;

  AST_PULSE_FLAGS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |-> squashing) else $error("pulse without flushing flag"); // R9
  AST_CONFLICT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> sq_vld) else $error("conflict without flush"); // R3
  AST_TRAP_GATES_EXE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend && !fire && !ctx_eff && exe_vld) |=> !sq_vld) else $error("exe flush during trap"); // R5
  AST_TRAP_END_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trap_pend) |-> sq_vld) else $error("trap ended without flush"); // R2
  AST_KILL_BOUND_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && sq_slot_kill) |-> (sq_bound == sq_done)) else $error("slot kill boundary"); // R6
  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (squashing && rob_done && !fire && !ctx_eff && !exe_vld) |=> !squashing) else $error("flag stuck"); // R9
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
  parameter int NUM_THR = 2,
  parameter int SEQ_W   = 32,
  parameter int PC_W    = 32,
  parameter int LAT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LAT_W-1:0]           trap_latency,
  input  logic [NUM_THR-1:0]         trap_req,
  input  logic [NUM_THR-1:0]         ctx_req,
  input  logic [NUM_THR-1:0]         exe_vld,
  input  logic [NUM_THR*SEQ_W-1:0]   exe_seq,
  input  logic [NUM_THR-1:0]         exe_mispredict,
  input  logic [NUM_THR-1:0]         exe_taken,
  input  logic [NUM_THR-1:0]         exe_cond_slot,
  input  logic [NUM_THR-1:0]         exe_incl_self,
  input  logic [NUM_THR*PC_W-1:0]    exe_pc,
  input  logic [NUM_THR-1:0]         disp_vld,
  input  logic [NUM_THR*SEQ_W-1:0]   disp_seq,
  input  logic [NUM_THR-1:0]         rob_empty,
  input  logic [NUM_THR*SEQ_W-1:0]   rob_head_seq,
  input  logic [NUM_THR-1:0]         rob_done,
  input  logic [NUM_THR*PC_W-1:0]    restart_pc,
  output logic [NUM_THR-1:0]         sq_vld,
  output logic [NUM_THR*SEQ_W-1:0]   sq_bound,
  output logic [NUM_THR*SEQ_W-1:0]   sq_done,
  output logic [NUM_THR-1:0]         sq_slot_kill,
  output logic [NUM_THR*PC_W-1:0]    sq_pc,
  output logic [NUM_THR-1:0]         squashing,
  output logic [NUM_THR-1:0]         trap_pend,
  output logic [NUM_THR-1:0]         conflict
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    sq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
      .clk            (clk),
      .rst_n          (rst_n),
      .trap_latency   (trap_latency),
      .trap_req       (trap_req[t]),
      .ctx_req        (ctx_req[t]),
      .exe_vld        (exe_vld[t]),
      .exe_seq        (exe_seq[t*SEQ_W +: SEQ_W]),
      .exe_mispredict (exe_mispredict[t]),
      .exe_taken      (exe_taken[t]),
      .exe_cond_slot  (exe_cond_slot[t]),
      .exe_incl_self  (exe_incl_self[t]),
      .exe_pc         (exe_pc[t*PC_W +: PC_W]),
      .disp_vld       (disp_vld[t]),
      .disp_seq       (disp_seq[t*SEQ_W +: SEQ_W]),
      .rob_empty      (rob_empty[t]),
      .rob_head_seq   (rob_head_seq[t*SEQ_W +: SEQ_W]),
      .rob_done       (rob_done[t]),
      .restart_pc     (restart_pc[t*PC_W +: PC_W]),
      .sq_vld         (sq_vld[t]),
      .sq_bound       (sq_bound[t*SEQ_W +: SEQ_W]),
      .sq_done        (sq_done[t*SEQ_W +: SEQ_W]),
      .sq_slot_kill   (sq_slot_kill[t]),
      .sq_pc          (sq_pc[t*PC_W +: PC_W]),
      .squashing      (squashing[t]),
      .trap_pend      (trap_pend[t]),
      .conflict       (conflict[t])
    );
  end

  AST_CONFLICT_ONEHOT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict & ~sq_vld) == '0) else $error("conflict outside flush"); // R13
endmodule

// File: tb/commit_squash_ctrl_tb.sv
`timescale 1ns/1ps
module commit_squash_ctrl_tb;
  localparam int NT = 2;
  localparam int SW = 32;
  localparam int PW = 32;
  localparam int LW = 8;

  typedef struct {
    logic [SW-1:0] bound;
    logic [SW-1:0] done;
    logic          kill;
    logic [PW-1:0] pc;
    logic          conf;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0]    trap_latency;
  logic [NT-1:0]    trap_req, ctx_req, exe_vld, exe_mispredict, exe_taken;
  logic [NT-1:0]    exe_cond_slot, exe_incl_self, disp_vld, rob_empty, rob_done;
  logic [NT*SW-1:0] exe_seq, disp_seq, rob_head_seq;
  logic [NT*PW-1:0] exe_pc, restart_pc;
  logic [NT-1:0]    sq_vld, sq_slot_kill, squashing, trap_pend, conflict;
  logic [NT*SW-1:0] sq_bound, sq_done;
  logic [NT*PW-1:0] sq_pc;

  int n_chk  = 0;
  int n_fail = 0;
  exp_t sb_q [NT][$];

  always #2 clk = ~clk;

  commit_squash_ctrl #(.NUM_THR(NT), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_latency(trap_latency), .trap_req(trap_req),
    .ctx_req(ctx_req), .exe_vld(exe_vld), .exe_seq(exe_seq),
    .exe_mispredict(exe_mispredict), .exe_taken(exe_taken),
    .exe_cond_slot(exe_cond_slot), .exe_incl_self(exe_incl_self), .exe_pc(exe_pc),
    .disp_vld(disp_vld), .disp_seq(disp_seq), .rob_empty(rob_empty),
    .rob_head_seq(rob_head_seq), .rob_done(rob_done), .restart_pc(restart_pc),
    .sq_vld(sq_vld), .sq_bound(sq_bound), .sq_done(sq_done),
    .sq_slot_kill(sq_slot_kill), .sq_pc(sq_pc), .squashing(squashing),
    .trap_pend(trap_pend), .conflict(conflict)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NT; t++) begin
        if (sq_vld[t]) begin
          if (sb_q[t].size() == 0) begin
            chk(1'b0, "R10 unexpected pulse", 64'(sq_bound[t*SW +: SW]), 64'hffff);
          end else begin
            exp_t e;
            e = sb_q[t].pop_front();
            chk(sq_bound[t*SW +: SW] == e.bound, e.req, 64'(sq_bound[t*SW +: SW]), 64'(e.bound));
            chk(sq_done[t*SW +: SW] == e.done, e.req, 64'(sq_done[t*SW +: SW]), 64'(e.done));
            chk(sq_slot_kill[t] == e.kill, e.req, 64'(sq_slot_kill[t]), 64'(e.kill));
            chk(sq_pc[t*PW +: PW] == e.pc, e.req, 64'(sq_pc[t*PW +: PW]), 64'(e.pc));
            chk(conflict[t] == e.conf, e.req, 64'(conflict[t]), 64'(e.conf));
          end
        end
      end
    end
  end

  function automatic exp_t exe_model(input logic [SW-1:0] s, input bit mp, input bit tk,
                                     input bit cs, input bit inc, input logic [PW-1:0] pc,
                                     input string req);
    exp_t e;
    e.kill = 1'b0;
    e.bound = s;
    if (mp) begin
      if (tk && cs) e.kill = 1'b1;
      else e.bound = s + 1;
    end
    e.done = s;
    if (inc) begin
      e.bound = e.bound - 1;
      e.done  = e.done - 1;
    end
    e.pc = pc;
    e.conf = 1'b0;
    e.req = req;
    return e;
  endfunction

  function automatic exp_t whole_model(input bit empty, input logic [SW-1:0] head,
                                       input logic [PW-1:0] pc, input bit conf, input string req);
    exp_t e;
    e.bound = empty ? '0 : head - 1;
    e.done = e.bound;
    e.kill = 1'b0;
    e.pc = pc;
    e.conf = conf;
    e.req = req;
    return e;
  endfunction

  task automatic set_exe(input int t, input logic [SW-1:0] s, input bit mp, input bit tk,
                         input bit cs, input bit inc, input logic [PW-1:0] pc);
    exe_vld[t] = 1'b1;
    exe_seq[t*SW +: SW] = s;
    exe_mispredict[t] = mp;
    exe_taken[t] = tk;
    exe_cond_slot[t] = cs;
    exe_incl_self[t] = inc;
    exe_pc[t*PW +: PW] = pc;
  endtask

  // driver: one execute request, pushing the expected item when it should pass
  task automatic drive_exe(input int t, input logic [SW-1:0] s, input bit mp, input bit tk,
                           input bit cs, input bit inc, input logic [PW-1:0] pc,
                           input bit expect_acc, input string req);
    set_exe(t, s, mp, tk, cs, inc, pc);
    if (expect_acc) sb_q[t].push_back(exe_model(s, mp, tk, cs, inc, pc, req));
    @(negedge clk);
    exe_vld[t] = 1'b0;
    if (!expect_acc) chk(sq_vld[t] == 1'b0, req, 64'(sq_vld[t]), 64'd0);
  endtask

  task automatic drive_disp(input int t, input logic [SW-1:0] s);
    disp_vld[t] = 1'b1;
    disp_seq[t*SW +: SW] = s;
    @(negedge clk);
    disp_vld[t] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    trap_latency = '0; trap_req = '0; ctx_req = '0; exe_vld = '0;
    exe_mispredict = '0; exe_taken = '0; exe_cond_slot = '0; exe_incl_self = '0;
    disp_vld = '0; rob_empty = '1; rob_done = '1;
    exe_seq = '0; disp_seq = '0; rob_head_seq = '0; exe_pc = '0; restart_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sq_vld == '0, "R1 sq_vld", 64'(sq_vld), 0);
    chk(squashing == '0, "R1 squashing", 64'(squashing), 0);
    chk(trap_pend == '0, "R1 trap_pend", 64'(trap_pend), 0);
    chk(conflict == '0, "R1 conflict", 64'(conflict), 0);
    chk(sq_bound == '0, "R1 bound", 64'(sq_bound), 0);

    // R11 dispatch then R6 branch cases
    drive_disp(0, 32'd100);
    drive_exe(0, 32'd50, 1, 1, 1, 0, 32'hA000, 1, "R6 taken cond slot");
    @(negedge clk);
    drive_exe(0, 32'd60, 0, 0, 0, 0, 32'hA004, 0, "R8 stale rejected");
    drive_exe(0, 32'd40, 1, 0, 0, 0, 32'hA008, 1, "R6 mispredict not slot");
    drive_exe(0, 32'd30, 0, 0, 0, 0, 32'hA00C, 1, "R6 no mispredict");
    // R7 include-self
    drive_exe(0, 32'd20, 1, 1, 1, 1, 32'hA010, 1, "R7 incl self slot");
    drive_exe(0, 32'd10, 1, 0, 0, 1, 32'hA014, 1, "R7 incl self plus one");
    drive_exe(0, 32'd10, 0, 0, 0, 0, 32'hA018, 0, "R8 above new youngest");
    // R11 dispatch raises youngest
    drive_disp(0, 32'd200);
    drive_exe(0, 32'd150, 0, 0, 0, 0, 32'hA01C, 1, "R11 after dispatch");

    // R9 flushing flag held while rob busy
    rob_done[0] = 1'b0;
    drive_exe(0, 32'd100, 0, 0, 0, 0, 32'hA020, 1, "R9 flush");
    for (int k = 0; k < 3; k++) begin
      chk(squashing[0] == 1'b1, "R9 held", 64'(squashing[0]), 1);
      @(negedge clk);
    end
    chk(squashing[0] == 1'b1, "R9 held last", 64'(squashing[0]), 1);
    rob_done[0] = 1'b1;
    @(negedge clk);
    chk(squashing[0] == 1'b0, "R9 released", 64'(squashing[0]), 0);

    // R2 trap latency 3, R5 exe gated while pending
    trap_latency = 8'd3;
    rob_empty[0] = 1'b0;
    rob_head_seq[0*SW +: SW] = 32'd77;
    restart_pc[0*PW +: PW] = 32'hB000;
    trap_req[0] = 1'b1;
    sb_q[0].push_back(whole_model(1'b0, 32'd77, 32'hB000, 1'b0, "R2 trap flush"));
    @(negedge clk);
    trap_req[0] = 1'b0;
    chk(trap_pend[0] == 1'b1, "R2 pending", 64'(trap_pend[0]), 1);
    chk(sq_vld[0] == 1'b0, "R2 early", 64'(sq_vld[0]), 0);
    drive_exe(0, 32'd5, 0, 0, 0, 0, 32'hA024, 0, "R5 trap pending gate");
    @(negedge clk);
    chk(sq_vld[0] == 1'b0, "R2 early", 64'(sq_vld[0]), 0);
    @(negedge clk);
    chk(sq_vld[0] == 1'b0 && trap_pend[0] == 1'b1, "R2 still waiting", 64'(sq_vld[0]), 0);
    @(negedge clk);
    chk(sq_vld[0] == 1'b1, "R2 fires", 64'(sq_vld[0]), 1);
    chk(trap_pend[0] == 1'b0, "R2 pend cleared", 64'(trap_pend[0]), 0);
    @(negedge clk);
    chk(sq_vld[0] == 1'b0, "R10 single cycle", 64'(sq_vld[0]), 0);

    // R4 youngest reset to zero
    drive_exe(0, 32'd1, 0, 0, 0, 0, 32'hA028, 0, "R4 youngest zero");
    drive_exe(0, 32'd0, 0, 0, 0, 0, 32'hA02C, 1, "R4 seq zero accepted");
    // R4 empty rob
    rob_empty[0] = 1'b1;
    ctx_req[0] = 1'b1;
    sb_q[0].push_back(whole_model(1'b1, 32'd0, 32'hB000, 1'b0, "R4 empty ctx flush"));
    @(negedge clk);
    ctx_req[0] = 1'b0;
    @(negedge clk);

    // R3 trap fires with ctx pending
    rob_empty[0] = 1'b0;
    rob_head_seq[0*SW +: SW] = 32'd500;
    trap_latency = 8'd0;
    trap_req[0] = 1'b1;
    @(negedge clk);
    trap_req[0] = 1'b0;
    ctx_req[0] = 1'b1;
    sb_q[0].push_back(whole_model(1'b0, 32'd500, 32'hB000, 1'b1, "R3 trap wins"));
    sb_q[0].push_back(whole_model(1'b0, 32'd500, 32'hB000, 1'b0, "R3 ctx follows"));
    @(negedge clk);
    ctx_req[0] = 1'b0;
    chk(conflict[0] == 1'b1, "R3 conflict", 64'(conflict[0]), 1);
    @(negedge clk);
    chk(sq_vld[0] == 1'b1, "R3 second flush", 64'(sq_vld[0]), 1);
    @(negedge clk);

    // R12 ctx and exe in same cycle
    drive_disp(0, 32'd300);
    ctx_req[0] = 1'b1;
    set_exe(0, 32'd200, 1, 0, 0, 0, 32'hA030);
    sb_q[0].push_back(whole_model(1'b0, 32'd500, 32'hB000, 1'b0, "R12 exe ignored"));
    @(negedge clk);
    ctx_req[0] = 1'b0;
    exe_vld[0] = 1'b0;
    @(negedge clk);

    // R13 thread independence
    drive_disp(1, 32'd1000);
    set_exe(0, 32'd900, 0, 0, 0, 0, 32'hC000);
    drive_exe(1, 32'd900, 0, 0, 0, 0, 32'hD000, 1, "R13 thread one");
    chk(sq_vld[0] == 1'b0, "R13 thread zero untouched", 64'(sq_vld[0]), 0);
    @(negedge clk);
    @(negedge clk);
    // R10 hold
    chk(sq_vld[1] == 1'b0, "R10 pulse ended", 64'(sq_vld[1]), 0);
    chk(sq_bound[1*SW +: SW] == 32'd900, "R10 data held", 64'(sq_bound[1*SW +: SW]), 900);

    for (int t = 0; t < NT; t++)
      chk(sb_q[t].size() == 0, "R10 missing pulses", 64'(sb_q[t].size()), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule